// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries out the register updates a small 32-bit core makes when it enters an exception handler. Four causes can start an entry: a bus fault, a break trap, a non-maskable interrupt and a maskable interrupt. In its idle state the sequencer samples the four request lines and the live core state: PC, condition-code register (CCS), stack pointer, kernel stack pointer, exception base register and delay-slot count. When it accepts a cause, it captures that state.

It then works out every new register value. These are the saved return address, the exception status word, the shifted CCS, and the stack pointer and user stack pointer. It next reads the handler address from the vector table through a request/valid read port. A single-cycle `done` pulse marks the cycle in which all results and their write enables are valid for the core to commit.

While an entry is in flight the request lines are not sampled. The `done` pulse also tells the core to drop its pending cause, so that a later bus fault is seen as a fresh event and not as a recursive one.

Top module: `exc_entry_seq`

## Requirements
- R1: A maskable interrupt is accepted only when CCS bit 8 (interrupt enable) is 1 and `irq_lock` is 0. An NMI is accepted only when CCS bit 9 (NMI enable) is 1. A request that is not accepted starts no entry: `busy` and `mem_req` stay 0.
- R2: When several causes are accepted in the same cycle, the winner follows the priority order bus fault, then break, then NMI, then maskable interrupt.
- R3: The vector depends on the cause. A break uses `trap_vec`, an NMI uses 0, a bus fault uses `fault_vec`, and a maskable interrupt uses `irq_vec`.
- R4: An NMI entry asserts `nrp_we` with `erp_we` low, and clears CCS bit 9 before the shift of R8. Every other cause asserts `erp_we` with `nrp_we` low. The saved value goes out on `ret_addr`.
- R5: `exs_o` carries the low 8 bits of the vector in bits 15:8, and all other bits are 0.
- R6: `ret_addr` equals the captured PC minus the delay-slot count. `dslot_clr` is 1 exactly when that count was nonzero.
- R7: When CCS bit 6 (user mode) is 1, `usp_we` is 1, `usp_o` equals the old stack pointer and `sp_o` equals `ksp`. Otherwise `usp_we` is 0 and `sp_o` equals the old stack pointer.
- R8: `ccs_o` = ((c & 0xC0000000) | ((c << 12) >> 2)) & ~0x3FF, computed in 32 bits, where c is the CCS after the NMI update of R4.
- R9: The handler is read at `ebp + 4*vector`, and `pc_o` equals the data returned for that read.
- R10: `mem_req` stays high, and `mem_addr` stays stable, until `mem_valid` is seen.
- R11: `done` is a single-cycle pulse. It comes 3+L cycles after the accepting edge's request cycle, where L is the number of wait cycles before `mem_valid`. Requests raised while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| brk_req | input | 1 | Break trap request |
| fault_req | input | 1 | Bus fault request |
| irq_lock | input | 1 | Blocks maskable interrupts when 1 |
| irq_vec | input | VEC_W | Vector from the interrupt controller |
| trap_vec | input | VEC_W | Programmable break vector |
| fault_vec | input | VEC_W | Vector reported with a bus fault |
| pc_i | input | 32 | Current PC |
| ccs_i | input | 32 | Current condition-code register |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| ebp_i | input | 32 | Exception vector table base |
| dslot_i | input | DS_W | Delay-slot count, 0 when not in a slot |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | 32 | Vector table read address |
| mem_rdata | input | 32 | Read data |
| mem_valid | input | 1 | Read data valid |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Results valid for one cycle |
| pc_o | output | 32 | Handler address |
| ret_addr | output | 32 | Return address to save |
| erp_we | output | 1 | Write return address to exception return register |
| nrp_we | output | 1 | Write return address to NMI return register |
| exs_o | output | 32 | Exception status word |
| ccs_o | output | 32 | New condition-code register |
| sp_o | output | 32 | New stack pointer |
| usp_o | output | 32 | Value for user stack pointer register |
| usp_we | output | 1 | Write user stack pointer register |
| dslot_clr | output | 1 | Clear delay-slot indication |

## Verification
Requests are sampled at one rising edge. `mem_req` rises two cycles later, and every result appears together with `done` on the cycle after `mem_valid`, which is 3+L cycles after the request for a memory that waits L cycles. The bench drives a request on a falling edge and counts falling edges until `done`. It requires `done` exactly at count 3+L, and only then compares each output against values computed from the requirements. For rejected requests it watches `busy` and `mem_req` over several cycles instead.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        CZ_IRQ   = 2'd0,
        CZ_NMI   = 2'd1,
        CZ_BRK   = 2'd2,
        CZ_FAULT = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SAVE  = 2'd1,
        S_FETCH = 2'd2,
        S_DONE  = 2'd3
    } seq_st_e;

    localparam int XLEN       = 32;
    localparam int CCS_U_BIT  = 6;
    localparam int CCS_I_BIT  = 8;
    localparam int CCS_M_BIT  = 9;
    localparam int FIELD_W    = 10;
    localparam logic [XLEN-1:0] CCS_KEEP = 32'hC000_0000;
    localparam logic [XLEN-1:0] CCS_LOW  = 32'h0000_03FF;
endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                irq_req,
    input  logic                nmi_req,
    input  logic                brk_req,
    input  logic                fault_req,
    input  logic                irq_lock,
    input  logic [XLEN-1:0]     ccs,
    input  logic [VEC_W-1:0]    irq_vec,
    input  logic [VEC_W-1:0]    trap_vec,
    input  logic [VEC_W-1:0]    fault_vec,
    output logic                take,
    output cause_e              cause,
    output logic [VEC_W-1:0]    vec
);
    logic irq_ok;
    logic nmi_ok;

    always_comb begin
        irq_ok = irq_req && ccs[CCS_I_BIT] && !irq_lock;
        nmi_ok = nmi_req && ccs[CCS_M_BIT];
        take   = fault_req || brk_req || nmi_ok || irq_ok;
        cause  = CZ_IRQ;
        vec    = irq_vec;
        if (fault_req) begin
            cause = CZ_FAULT;
            vec   = fault_vec;
        end else if (brk_req) begin
            cause = CZ_BRK;
            vec   = trap_vec;
        end else if (nmi_ok) begin
            cause = CZ_NMI;
            vec   = '0;
        end
    end
endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc
    import exc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int DS_W  = 2
) (
    input  cause_e              cause,
    input  logic [VEC_W-1:0]    vec,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     ccs,
    input  logic [XLEN-1:0]     sp,
    input  logic [XLEN-1:0]     ksp,
    input  logic [DS_W-1:0]     dslot,
    output logic [XLEN-1:0]     ret_addr,
    output logic                ret_to_nrp,
    output logic [XLEN-1:0]     exs,
    output logic [XLEN-1:0]     ccs_new,
    output logic [XLEN-1:0]     sp_new,
    output logic [XLEN-1:0]     usp_val,
    output logic                usp_we,
    output logic                ds_clr
);
    logic [XLEN-1:0] ccs_m;
    logic [XLEN-1:0] ccs_up;
    logic [XLEN-1:0] vec_ext;

    always_comb begin
        ret_to_nrp = (cause == CZ_NMI);
        ccs_m      = ccs;
        if (ret_to_nrp) begin
            ccs_m[CCS_M_BIT] = 1'b0;
        end
        // move every flag field one field upward, keep the two top bits
        ccs_up   = (ccs_m << (FIELD_W + 2)) >> 2;
        ccs_new  = ((ccs_m & CCS_KEEP) | ccs_up) & ~CCS_LOW;

        ret_addr = pc - XLEN'(dslot);
        ds_clr   = (dslot != '0);

        vec_ext  = XLEN'(vec);
        exs      = {16'h0000, vec_ext[7:0], 8'h00};

        usp_we   = ccs[CCS_U_BIT];
        usp_val  = sp;
        sp_new   = usp_we ? ksp : sp;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int DS_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_req,
    input  logic                nmi_req,
    input  logic                brk_req,
    input  logic                fault_req,
    input  logic                irq_lock,
    input  logic [VEC_W-1:0]    irq_vec,
    input  logic [VEC_W-1:0]    trap_vec,
    input  logic [VEC_W-1:0]    fault_vec,
    input  logic [31:0]         pc_i,
    input  logic [31:0]         ccs_i,
    input  logic [31:0]         sp_i,
    input  logic [31:0]         ksp_i,
    input  logic [31:0]         ebp_i,
    input  logic [DS_W-1:0]     dslot_i,
    output logic                mem_req,
    output logic [31:0]         mem_addr,
    input  logic [31:0]         mem_rdata,
    input  logic                mem_valid,
    output logic                busy,
    output logic                done,
    output logic [31:0]         pc_o,
    output logic [31:0]         ret_addr,
    output logic                erp_we,
    output logic                nrp_we,
    output logic [31:0]         exs_o,
    output logic [31:0]         ccs_o,
    output logic [31:0]         sp_o,
    output logic [31:0]         usp_o,
    output logic                usp_we,
    output logic                dslot_clr
);
    localparam int VEC_SHIFT = 2;

    typedef struct packed {
        seq_st_e            st;
        cause_e             cause;
        logic [VEC_W-1:0]   vec;
        logic [XLEN-1:0]    pc;
        logic [XLEN-1:0]    ccs;
        logic [XLEN-1:0]    sp;
        logic [XLEN-1:0]    ksp;
        logic [XLEN-1:0]    ebp;
        logic [DS_W-1:0]    dslot;
        logic [XLEN-1:0]    new_pc;
        logic [XLEN-1:0]    ret;
        logic [XLEN-1:0]    exs;
        logic [XLEN-1:0]    ccs_n;
        logic [XLEN-1:0]    sp_n;
        logic [XLEN-1:0]    usp;
        logic               to_nrp;
        logic               usp_w;
        logic               ds_c;
    } seq_t;

    seq_t s_d, s_q;

    logic               sel_take;
    cause_e             sel_cause;
    logic [VEC_W-1:0]   sel_vec;

    logic [XLEN-1:0]    c_ret, c_exs, c_ccs, c_sp, c_usp;
    logic               c_nrp, c_usp_we, c_ds_clr;

    exc_cause_sel #(.VEC_W(VEC_W)) u_sel (
        .irq_req   (irq_req),
        .nmi_req   (nmi_req),
        .brk_req   (brk_req),
        .fault_req (fault_req),
        .irq_lock  (irq_lock),
        .ccs       (ccs_i),
        .irq_vec   (irq_vec),
        .trap_vec  (trap_vec),
        .fault_vec (fault_vec),
        .take      (sel_take),
        .cause     (sel_cause),
        .vec       (sel_vec)
    );

    exc_ctx_calc #(.VEC_W(VEC_W), .DS_W(DS_W)) u_calc (
        .cause      (s_q.cause),
        .vec        (s_q.vec),
        .pc         (s_q.pc),
        .ccs        (s_q.ccs),
        .sp         (s_q.sp),
        .ksp        (s_q.ksp),
        .dslot      (s_q.dslot),
        .ret_addr   (c_ret),
        .ret_to_nrp (c_nrp),
        .exs        (c_exs),
        .ccs_new    (c_ccs),
        .sp_new     (c_sp),
        .usp_val    (c_usp),
        .usp_we     (c_usp_we),
        .ds_clr     (c_ds_clr)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            S_IDLE: begin
                if (sel_take) begin
                    s_d.st    = S_SAVE;
                    s_d.cause = sel_cause;
                    s_d.vec   = sel_vec;
                    s_d.pc    = pc_i;
                    s_d.ccs   = ccs_i;
                    s_d.sp    = sp_i;
                    s_d.ksp   = ksp_i;
                    s_d.ebp   = ebp_i;
                    s_d.dslot = dslot_i;
                end
            end
            S_SAVE: begin
                s_d.st     = S_FETCH;
                s_d.ret    = c_ret;
                s_d.to_nrp = c_nrp;
                s_d.exs    = c_exs;
                s_d.ccs_n  = c_ccs;
                s_d.sp_n   = c_sp;
                s_d.usp    = c_usp;
                s_d.usp_w  = c_usp_we;
                s_d.ds_c   = c_ds_clr;
            end
            S_FETCH: begin
                if (mem_valid) begin
                    s_d.st     = S_DONE;
                    s_d.new_pc = mem_rdata;
                end
            end
            S_DONE: begin
                s_d.st = S_IDLE;
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        mem_req   = (s_q.st == S_FETCH);
        mem_addr  = s_q.ebp + (XLEN'(s_q.vec) << VEC_SHIFT);
        busy      = (s_q.st != S_IDLE);
        done      = (s_q.st == S_DONE);
        pc_o      = s_q.new_pc;
        ret_addr  = s_q.ret;
        erp_we    = done && !s_q.to_nrp;
        nrp_we    = done && s_q.to_nrp;
        exs_o     = s_q.exs;
        ccs_o     = s_q.ccs_n;
        sp_o      = s_q.sp_n;
        usp_o     = s_q.usp;
        usp_we    = done && s_q.usp_w;
        dslot_clr = done && s_q.ds_c;
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_valid,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_rdata,
    input logic [31:0] pc_o,
    input logic [31:0] exs_o,
    input logic [31:0] ccs_o,
    input logic        erp_we,
    input logic        nrp_we
);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_addr_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_pc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (done && pc_o == $past(mem_rdata)));

    p_exs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (exs_o[31:16] == 16'h0 && exs_o[7:0] == 8'h0));

    p_ccs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ccs_o[9:0] == 10'h0));

    p_one_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({erp_we, nrp_we}) == 1));

    p_we_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(erp_we || nrp_we));
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .pc_o      (pc_o),
    .exs_o     (exs_o),
    .ccs_o     (ccs_o),
    .erp_we    (erp_we),
    .nrp_we    (nrp_we)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    localparam logic [31:0] SP_V   = 32'h7000_0010;
    localparam logic [31:0] KSP_V  = 32'h8000_0F00;
    localparam logic [31:0] EBP_V  = 32'h0001_0000;
    localparam logic [7:0]  IVEC_V = 8'h21;
    localparam logic [7:0]  TVEC_V = 8'h13;
    localparam logic [7:0]  FVEC_V = 8'h4E;

    // req bits: {fault, brk, nmi, irq}
    typedef struct packed {
        logic [3:0]  req;
        logic        lock;
        logic [31:0] ccs;
        logic [31:0] pc;
        logic [1:0]  ds;
        logic [2:0]  lat;
    } tv_t;

    localparam int NV = 13;
    localparam tv_t TV [NV] = '{
        '{4'b0001, 1'b0, 32'h0000_0100, 32'h0000_1000, 2'd0, 3'd0},
        '{4'b0001, 1'b0, 32'h0000_0140, 32'h0000_2004, 2'd1, 3'd2},
        '{4'b0001, 1'b1, 32'h0000_0100, 32'h0000_2100, 2'd0, 3'd0},
        '{4'b0001, 1'b0, 32'h0000_0040, 32'h0000_2200, 2'd0, 3'd0},
        '{4'b0010, 1'b0, 32'h0000_0200, 32'h0000_3000, 2'd0, 3'd1},
        '{4'b0010, 1'b0, 32'h0000_0100, 32'h0000_3100, 2'd0, 3'd0},
        '{4'b0011, 1'b0, 32'h0000_0340, 32'h0000_3208, 2'd2, 3'd0},
        '{4'b0100, 1'b0, 32'hC00F_FFFF, 32'h0000_4008, 2'd0, 3'd3},
        '{4'b1000, 1'b0, 32'h8000_0001, 32'h0000_5000, 2'd1, 3'd0},
        '{4'b1111, 1'b0, 32'h0000_03FF, 32'h0000_6000, 2'd0, 3'd1},
        '{4'b0110, 1'b0, 32'h0000_0200, 32'h0000_7000, 2'd0, 3'd0},
        '{4'b0011, 1'b0, 32'h0000_0100, 32'h0000_7100, 2'd0, 3'd0},
        '{4'b0010, 1'b0, 32'hFFFF_FFFF, 32'h0000_8000, 2'd3, 3'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 0, nmi_req = 0, brk_req = 0, fault_req = 0, irq_lock = 0;
    logic [31:0] pc_i = '0, ccs_i = '0;
    logic [1:0]  dslot_i = '0;
    logic        mem_req, mem_valid, busy, done;
    logic [31:0] mem_addr, mem_rdata;
    logic [31:0] pc_o, ret_addr, exs_o, ccs_o, sp_o, usp_o;
    logic        erp_we, nrp_we, usp_we, dslot_clr;

    logic [2:0]  lat_cur = '0;
    logic [3:0]  mcnt;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] handler(input logic [31:0] a);
        return a * 32'h0000_9E37 + 32'h5A5A_0000;
    endfunction

    always_ff @(posedge clk) begin
        if (!mem_req) mcnt <= '0;
        else          mcnt <= mcnt + 4'd1;
    end
    assign mem_valid = mem_req && (mcnt == {1'b0, lat_cur});
    assign mem_rdata = handler(mem_addr);

    exc_entry_seq #(.VEC_W(8), .DS_W(2)) i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .irq_req(irq_req), .nmi_req(nmi_req), .brk_req(brk_req), .fault_req(fault_req),
        .irq_lock(irq_lock), .irq_vec(IVEC_V), .trap_vec(TVEC_V), .fault_vec(FVEC_V),
        .pc_i(pc_i), .ccs_i(ccs_i), .sp_i(SP_V), .ksp_i(KSP_V), .ebp_i(EBP_V),
        .dslot_i(dslot_i), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid), .busy(busy), .done(done),
        .pc_o(pc_o), .ret_addr(ret_addr), .erp_we(erp_we), .nrp_we(nrp_we),
        .exs_o(exs_o), .ccs_o(ccs_o), .sp_o(sp_o), .usp_o(usp_o),
        .usp_we(usp_we), .dslot_clr(dslot_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic [3:0] r);
        fault_req = r[3];
        brk_req   = r[2];
        nmi_req   = r[1];
        irq_req   = r[0];
    endtask

    // drive one request at a falling edge; return falling edges until done (99 = never)
    task automatic fire(input tv_t v, output int waited);
        waited = 99;
        irq_lock = v.lock;
        ccs_i    = v.ccs;
        pc_i     = v.pc;
        dslot_i  = v.ds;
        lat_cur  = v.lat;
        set_req(v.req);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            set_req(4'b0000);
            if (done) begin
                waited = k;
                break;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // reset state (R11)
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset done", {31'd0, done}, 32'd0);
        chk("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            tv_t v;
            logic take, is_nmi, user;
            logic [7:0]  vec;
            logic [31:0] c1, exp_ccs, addr;
            v = TV[i];
            take = 1'b1; is_nmi = 1'b0; vec = IVEC_V;
            if (v.req[3])                      vec = FVEC_V;
            else if (v.req[2])                 vec = TVEC_V;
            else if (v.req[1] && v.ccs[9])     begin vec = 8'h00; is_nmi = 1'b1; end
            else if (v.req[0] && v.ccs[8] && !v.lock) vec = IVEC_V;
            else                               take = 1'b0;
            c1 = v.ccs;
            if (is_nmi) c1[9] = 1'b0;
            exp_ccs = ((c1 & 32'hC000_0000) | ((c1 << 12) >> 2)) & ~32'h3FF;
            user = v.ccs[6];
            addr = EBP_V + {22'd0, vec, 2'b00};

            if (!take) begin
                // R1: masked request starts nothing
                set_req(v.req);
                irq_lock = v.lock;
                ccs_i = v.ccs;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    set_req(4'b0000);
                    chk($sformatf("R1 vec%0d busy", i), {31'd0, busy}, 32'd0);
                    chk($sformatf("R1 vec%0d mem_req", i), {31'd0, mem_req}, 32'd0);
                end
                irq_lock = 1'b0;
                continue;
            end

            fire(v, w);
            chk($sformatf("R11 vec%0d done latency", i), w, 3 + int'(v.lat));
            chk($sformatf("R3 R2 vec%0d exs", i), exs_o, {16'h0, vec, 8'h0});
            chk($sformatf("R5 vec%0d exs layout", i), exs_o & 32'hFFFF_00FF, 32'h0);
            chk($sformatf("R4 vec%0d erp_we", i), {31'd0, erp_we}, {31'd0, !is_nmi});
            chk($sformatf("R4 vec%0d nrp_we", i), {31'd0, nrp_we}, {31'd0, is_nmi});
            chk($sformatf("R6 vec%0d ret_addr", i), ret_addr, v.pc - {30'd0, v.ds});
            chk($sformatf("R6 vec%0d dslot_clr", i), {31'd0, dslot_clr}, {31'd0, v.ds != 2'd0});
            chk($sformatf("R8 vec%0d ccs", i), ccs_o, exp_ccs);
            chk($sformatf("R7 vec%0d usp_we", i), {31'd0, usp_we}, {31'd0, user});
            chk($sformatf("R7 vec%0d sp", i), sp_o, user ? KSP_V : SP_V);
            if (user) chk($sformatf("R7 vec%0d usp", i), usp_o, SP_V);
            chk($sformatf("R9 vec%0d pc", i), pc_o, handler(addr));
            @(negedge clk);
            chk($sformatf("R11 vec%0d done pulse", i), {31'd0, done}, 32'd0);
        end

        // R11: requests while busy are ignored; R10: long wait
        begin
            tv_t v;
            v = '{4'b0010, 1'b0, 32'h0000_0300, 32'h0000_9000, 2'd0, 3'd6};
            irq_lock = 1'b0;
            ccs_i = v.ccs; pc_i = v.pc; dslot_i = v.ds; lat_cur = v.lat;
            set_req(v.req);
            @(negedge clk);
            set_req(4'b0000);
            @(negedge clk);
            @(negedge clk);
            chk("R10 mem_req raised", {31'd0, mem_req}, 32'd1);
            chk("R10 mem_addr", mem_addr, EBP_V);
            set_req(4'b1001);
            @(negedge clk);
            set_req(4'b0000);
            chk("R10 mem_req held", {31'd0, mem_req}, 32'd1);
            chk("R10 mem_addr held", mem_addr, EBP_V);
            while (!done) @(negedge clk);
            chk("R11 busy entry kept nmi", {31'd0, nrp_we}, 32'd1);
            chk("R11 busy entry pc", pc_o, handler(EBP_V));
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk("R11 ignored request no entry", {31'd0, busy}, 32'd0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule